// File: doc/BRIEF.md
# Encoded-Interval Watchdog Timer

This block is a watchdog timer driven by a 16 Hz tick that comes from outside the block. Software sets it up with one control byte. Two low bits give a resolution. The five bits above them give a multiplier. The top bit chooses what happens when the timer runs out: a system reset request or an interrupt pulse. Software must either write the control byte or read it back before the countdown reaches zero. Either access reloads the countdown.

A read-only status register has a sticky timeout flag. An auxiliary byte register sits next to the control byte and is used by software for its own data. When the watchdog expires in reset mode, it clears bit 6 of the auxiliary register and also clears the control byte. After that the watchdog stays disarmed until software programs it again.

The register port uses a 2-bit address. Address 0 is the status register, address 1 the control byte, address 2 the auxiliary register, and address 3 is unused. Read data is combinational from the address. Writes and reads take effect on the clock edge where their enable is high.

Top module: `wdt_encoded_top`

## Requirements
- R1: After a restart, expiry happens on exactly the N-th tick, where N = ctrl[6:2] × 4^ctrl[1:0] (ctrl is the control byte at address 1). A tick is one cycle with `tick_16hz` high.
- R2: If N is zero (control byte 0x00, or a multiplier of zero), the watchdog is disabled. No number of ticks produces a pulse.
- R3: A write to address 1 stores the byte, clears the timeout flag and restarts the countdown with the new value. A restart in the same cycle as a tick takes precedence over that tick.
- R4: A read of address 1 restarts the countdown from the stored byte without changing that byte.
- R5: Expiry sets the timeout flag, which is bit 7 of address 0. Bits 6:0 of address 0 always read zero. The flag stays set until the next write to address 1.
- R6: If ctrl[7] is 1 at expiry, `reset_req` is high for exactly one cycle and `irq_pulse` stays low. The control byte becomes 0x00 and bit 6 of address 2 is cleared. The other bits of address 2 are unchanged.
- R7: If ctrl[7] is 0 at expiry, `irq_pulse` is high for exactly one cycle and `reset_req` stays low. The control byte keeps its value.
- R8: Host writes to address 0 have no effect on the timeout flag.
- R9: After expiry the countdown stops. No further pulse occurs until the next restart.
- R10: After reset, all three registers read 0x00, both outputs are low, and address 3 always reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_wr | input | 1 | Write enable |
| reg_rd | input | 1 | Read enable; a read of address 1 restarts the countdown |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| tick_16hz | input | 1 | One-cycle tick at 16 Hz |
| irq_pulse | output | 1 | One-cycle expiry interrupt |
| reset_req | output | 1 | One-cycle expiry reset request |

## Verification
The checker assumes that `reg_wr` and `reg_rd` are never high together for different addresses. It also assumes that a status flag rising can only come from expiry, so a pulse must go with every rise of the flag. The stimulus drives one register access at a time, and only at the falling edge. Ticks are kept one cycle wide and apart from accesses, except where a corner case needs them together. Random control bytes use small multipliers and resolutions so that every interval ends quickly. A directed run covers the largest encoding, 0x7F.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    localparam int DATA_W    = 8;
    localparam int ADDR_W    = 2;
    localparam int MULT_W    = 5;
    localparam int RES_W     = 2;
    // largest interval: max multiplier shifted by 2*(max resolution)
    localparam int CNT_W     = MULT_W + 2 * ((1 << RES_W) - 1);
    localparam int FLAG_BIT  = 7;
    localparam int AUX_CLR   = 6;

    typedef enum logic [ADDR_W-1:0] {
        A_STATUS = 2'd0,
        A_CTRL   = 2'd1,
        A_AUX    = 2'd2,
        A_SPARE  = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic              steer_rst;
        logic [MULT_W-1:0] mult;
        logic [RES_W-1:0]  res;
    } wdt_ctrl_t;

    typedef logic [CNT_W-1:0] wdt_cnt_t;

    function automatic wdt_cnt_t interval_of(input wdt_ctrl_t c);
        wdt_cnt_t base;
        base = CNT_W'(c.mult);
        return base << (2 * int'(c.res));
    endfunction

endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
    import wdt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              expire,
    output wdt_ctrl_t         ctrl_q,
    output logic              flag_q,
    output logic [DATA_W-1:0] aux_q,
    output logic [DATA_W-1:0] rd_data
);

    logic              wr_ctrl;
    logic              wr_aux;
    logic              rst_kind;
    wdt_ctrl_t         ctrl_d;
    logic              flag_d;
    logic [DATA_W-1:0] aux_d;

    assign wr_ctrl  = wr_en && (addr == A_CTRL);
    assign wr_aux   = wr_en && (addr == A_AUX);
    assign rst_kind = expire && ctrl_q.steer_rst;

    always_comb begin
        ctrl_d = ctrl_q;
        flag_d = flag_q;
        aux_d  = aux_q;
        if (wr_ctrl) begin
            ctrl_d = wdt_ctrl_t'(wr_data);
            flag_d = 1'b0;
        end else if (rst_kind) begin
            ctrl_d = '0;
        end
        if (expire) begin
            flag_d = 1'b1;
        end
        if (wr_aux) begin
            aux_d = wr_data;
        end
        if (rst_kind) begin
            aux_d[AUX_CLR] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            flag_q <= 1'b0;
            aux_q  <= '0;
        end else begin
            ctrl_q <= ctrl_d;
            flag_q <= flag_d;
            aux_q  <= aux_d;
        end
    end

    always_comb begin
        rd_data = '0;
        case (reg_addr_e'(addr))
            A_STATUS: rd_data[FLAG_BIT] = flag_q;
            A_CTRL:   rd_data = DATA_W'(ctrl_q);
            A_AUX:    rd_data = aux_q;
            default:  rd_data = '0;
        endcase
    end

endmodule

// File: rtl/wdt_counter.sv
module wdt_counter
    import wdt_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     restart,
    input  logic     tick,
    input  wdt_cnt_t load_val,
    output logic     expire
);

    wdt_cnt_t cnt_q;
    logic     run_q;
    logic     last;

    assign last   = (cnt_q == CNT_W'(1));
    assign expire = run_q && tick && !restart && last;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            run_q <= 1'b0;
        end else if (restart) begin
            cnt_q <= load_val;
            run_q <= (load_val != '0);
        end else if (run_q && tick) begin
            cnt_q <= cnt_q - CNT_W'(1);
            if (last) begin
                run_q <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/wdt_pulse.sv
module wdt_pulse (
    input  logic clk,
    input  logic rst,
    input  logic expire,
    input  logic steer_rst,
    output logic irq_pulse,
    output logic reset_req
);

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_pulse <= 1'b0;
            reset_req <= 1'b0;
        end else begin
            irq_pulse <= expire && !steer_rst;
            reset_req <= expire && steer_rst;
        end
    end

endmodule

// File: rtl/wdt_encoded_top.sv
module wdt_encoded_top
    import wdt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              reg_wr,
    input  logic              reg_rd,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              tick_16hz,
    output logic              irq_pulse,
    output logic              reset_req
);

    wdt_ctrl_t         ctrl_q;
    logic              flag_q;
    logic [DATA_W-1:0] aux_q;
    logic              expire;
    logic              restart;
    wdt_ctrl_t         load_src;
    wdt_cnt_t          load_val;

    // write data takes precedence over the stored byte when both access it
    assign restart  = (reg_wr || reg_rd) && (reg_addr == A_CTRL);
    assign load_src = reg_wr ? wdt_ctrl_t'(reg_wdata) : ctrl_q;
    assign load_val = interval_of(load_src);

    wdt_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (reg_wr),
        .addr    (reg_addr),
        .wr_data (reg_wdata),
        .expire  (expire),
        .ctrl_q  (ctrl_q),
        .flag_q  (flag_q),
        .aux_q   (aux_q),
        .rd_data (reg_rdata)
    );

    wdt_counter u_cnt (
        .clk      (clk),
        .rst      (rst),
        .restart  (restart),
        .tick     (tick_16hz),
        .load_val (load_val),
        .expire   (expire)
    );

    wdt_pulse u_pulse (
        .clk       (clk),
        .rst       (rst),
        .expire    (expire),
        .steer_rst (ctrl_q.steer_rst),
        .irq_pulse (irq_pulse),
        .reset_req (reset_req)
    );

endmodule

// File: rtl/wdt_checker.sv
module wdt_checker
    import wdt_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              irq_pulse,
    input logic              reset_req,
    input logic [DATA_W-1:0] ctrl_b,
    input logic              flag_q,
    input logic [DATA_W-1:0] aux_q
);

    // R7
    irq_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        irq_pulse |=> !irq_pulse);

    // R6
    rst_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        reset_req |=> !reset_req);

    // R6
    pulse_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        !(irq_pulse && reset_req));

    // R5
    flag_with_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_pulse || reset_req) |-> flag_q);

    // R8
    flag_rise_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(flag_q) |-> (irq_pulse || reset_req));

    // R6
    rst_clears_regs_chk: assert property (@(posedge clk) disable iff (rst)
        reset_req |-> (ctrl_b == '0 && !aux_q[AUX_CLR]));

    // R3
    ctrl_write_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == A_CTRL) |=> !flag_q);

    // R7
    irq_keeps_ctrl_chk: assert property (@(posedge clk) disable iff (rst)
        irq_pulse |-> (ctrl_b != '0));

endmodule

bind wdt_encoded_top wdt_checker u_wdt_chk (
    .clk       (clk),
    .rst       (rst),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .irq_pulse (irq_pulse),
    .reset_req (reset_req),
    .ctrl_b    (8'(ctrl_q)),
    .flag_q    (flag_q),
    .aux_q     (aux_q)
);

// File: tb/tb_wdt_encoded_top.sv
module tb_wdt_encoded_top;

    localparam int CLK_PERIOD = 10;
    localparam int MAX_CYCLES = 200000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic       reg_wr = 1'b0;
    logic       reg_rd = 1'b0;
    logic [7:0] reg_rdata;
    logic       tick_16hz = 1'b0;
    logic       irq_pulse;
    logic       reset_req;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    wdt_encoded_top dut (
        .clk       (clk),
        .rst       (rst),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_rdata (reg_rdata),
        .tick_16hz (tick_16hz),
        .irq_pulse (irq_pulse),
        .reset_req (reset_req)
    );

    function automatic int exp_ticks(input logic [7:0] c);
        return int'(c[6:2]) << (2 * int'(c[1:0]));
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    // one tick; returns the outputs seen in the cycle after the tick edge
    task automatic tick(output logic irq, output logic rq);
        @(negedge clk);
        tick_16hz = 1'b1;
        @(negedge clk);
        tick_16hz = 1'b0;
        irq = irq_pulse;
        rq  = reset_req;
    endtask

    task automatic ticks(input int n, output int pulses);
        logic i, r;
        pulses = 0;
        for (int k = 0; k < n; k++) begin
            tick(i, r);
            if (i || r) pulses++;
        end
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (MAX_CYCLES) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [7:0] d;
        logic       i, r;
        int         p;
        void'($urandom(32'd20240611));

        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R10 reset state
        rd(2'd0, d); chk("R10 status", d, 0);
        rd(2'd2, d); chk("R10 aux", d, 0);
        rd(2'd1, d); chk("R10 ctrl", d, 0);
        rd(2'd3, d); chk("R10 spare", d, 0);
        chk("R10 outputs", {irq_pulse, reset_req}, 0);

        // R1 R7 interrupt mode, 4 ticks
        wr(2'd1, 8'h05);
        ticks(3, p); chk("R1 early pulse", p, 0);
        tick(i, r);
        chk("R7 irq", i, 1); chk("R7 no reset", r, 0);
        @(negedge clk); chk("R7 single cycle", irq_pulse, 0);
        rd(2'd0, d); chk("R5 flag set", d, 8'h80);
        ticks(10, p); chk("R9 stopped", p, 0);
        // R8 status write ignored
        wr(2'd0, 8'h00);
        rd(2'd0, d); chk("R8 flag kept", d, 8'h80);
        rd(2'd1, d); chk("R7 ctrl kept", d, 8'h05);

        // R3 write clears flag
        wr(2'd1, 8'h09);
        rd(2'd0, d); chk("R3 flag cleared", d, 0);
        // R4 read restarts: 5 ticks, read, then 8 more
        ticks(5, p); chk("R4 before read", p, 0);
        rd(2'd1, d); chk("R4 ctrl unchanged", d, 8'h09);
        ticks(7, p); chk("R4 no early pulse", p, 0);
        tick(i, r); chk("R4 expiry after read", i, 1);

        // R3 restart beats a simultaneous tick
        @(negedge clk);
        reg_addr = 2'd1; reg_wdata = 8'h04; reg_wr = 1'b1; tick_16hz = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; tick_16hz = 1'b0;
        chk("R3 same-cycle tick", irq_pulse, 0);
        tick(i, r); chk("R3 reload then expire", i, 1);

        // R6 reset mode
        wr(2'd2, 8'hFF);
        wr(2'd1, 8'h84);
        tick(i, r);
        chk("R6 reset req", r, 1); chk("R6 no irq", i, 0);
        @(negedge clk); chk("R6 single cycle", reset_req, 0);
        rd(2'd2, d); chk("R6 aux bit6", d, 8'hBF);
        rd(2'd0, d); chk("R6 flag", d, 8'h80);
        rd(2'd1, d); chk("R6 ctrl cleared", d, 0);
        ticks(20, p); chk("R9 disarmed after reset", p, 0);

        // R2 disabled encodings
        wr(2'd1, 8'h00);
        ticks(100, p); chk("R2 zero byte", p, 0);
        wr(2'd1, 8'h03);
        ticks(100, p); chk("R2 zero multiplier", p, 0);
        wr(2'd0, 8'hFF);
        rd(2'd0, d); chk("R8 status not writable", d, 0);

        // R1 largest interval
        wr(2'd1, 8'h7F);
        ticks(exp_ticks(8'h7F) - 1, p); chk("R1 max early", p, 0);
        tick(i, r); chk("R1 max expiry", i, 1);

        // random intervals, modes and read restarts
        for (int it = 0; it < 24; it++) begin
            logic [7:0] c, a;
            int n, pre, seen;
            c = {1'($urandom_range(0, 1)), 5'($urandom_range(1, 7)),
                 2'($urandom_range(0, 2))};
            a = 8'($urandom);
            n = exp_ticks(c);
            wr(2'd2, a);
            wr(2'd1, c);
            if ($urandom_range(0, 1) == 1) begin
                pre = $urandom_range(0, n - 1);
                ticks(pre, p); chk("R4 random pre-read", p, 0);
                rd(2'd1, d);
            end
            seen = 0;
            for (int k = 1; k <= n + 2 && seen == 0; k++) begin
                tick(i, r);
                if (i || r) begin
                    seen = k;
                    chk(c[7] ? "R6 random kind" : "R7 random kind",
                        {i, r}, c[7] ? 1 : 2);
                end
            end
            chk("R1 random interval", seen, n);
            rd(2'd2, d);
            chk("R6 random aux", d, c[7] ? (a & 8'hBF) : a);
            rd(2'd1, d);
            chk("R7 random ctrl", d, c[7] ? 0 : c);
        end

        finish_run();
    end

endmodule